// File: doc/BRIEF.md
# LCD Command List Dispatcher

This block keeps a short list of display-controller entries that a host writes into indexed slots. Each entry says whether its 16-bit value is a command or a data word. After the host sets the number of entries and starts a run, the block hands the entries to a parallel display bus engine in slot order. It uses a valid/ready handshake and moves to the next slot only when the engine accepts the current one.

The host sees a small register window. It holds a control word with the entry count, a list-enable bit and four layer-enable bits. It also holds a run bit, a busy status, an interrupt enable and an interrupt status. A run starts when the run bit goes from 0 to 1. Writing 0 to the run bit stops the interface at once. When the list is finished, a completion status bit is set, and the interrupt line is raised if it is enabled.

Top module: `lcd_cmd_dispatch`

## Requirements
- R1: After reset the busy status (byte address 0x08, bit 0), the completion status (0x10, bit 0), the control word (0x00), `bus_valid` and `irq` are all zero.
- R2: Slot k is written and read at byte address 0x80 + 4·k, for k from 0 to 31. Bit 23 of a slot word is the command flag and bits 15:0 are the value. A read returns only these bits, with every other bit zero.
- R3: A run is triggered by writing 1 to bit 0 of the run register (0x04) while that bit holds 0. Writing 1 while it already holds 1 starts nothing.
- R4: On a run with entry count N (control bits 12:8, sampled at the trigger), slots 0 to N-1 are presented in increasing order. `bus_is_cmd` is the slot's bit 23 and `bus_data` is its bits 15:0.
- R5: While `bus_valid` is high and `bus_ready` is low, the presented entry does not change and `bus_valid` stays high, unless a stop is written.
- R6: Busy goes high on the clock edge that takes the trigger write. It stays high until the edge on which the last entry is accepted, and then clears on that edge.
- R7: If N is 0, or the list-enable bit (control bit 15) is clear, or any layer-enable bit (control bits 31:28) is set, the run issues no bus cycles. Busy is high for exactly one cycle and the completion status is set.
- R8: The completion status is set when a run finishes and is cleared by writing 1 to bit 0 of 0x10. `irq` equals that status ANDed with interrupt-enable bit 0 at 0x0C.
- R9: Writing 0 to the run bit during a run aborts it on that edge. `bus_valid` and busy drop, and the completion status is not set.
- R10: Writes to the slots and to the control word are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| bus_valid | output | 1 | An entry is offered to the bus engine |
| bus_is_cmd | output | 1 | Offered entry is a command (1) or data (0) |
| bus_data | output | 16 | Offered entry value |
| bus_ready | input | 1 | Bus engine accepts the offered entry |
| irq | output | 1 | Completion interrupt |

## Verification
The embedded properties assume a few things about the inputs. Reset is applied before the first operation. Each host write lasts one cycle. `bus_ready` may do anything, including staying low for long stretches. The stimulus drives every input on the falling edge, so the engine's ready and the host strobe are stable through each rising edge. Random runs use random counts, slot contents, flags, enables and ready duty cycles. Directed cases stall the engine to exercise the hold, write-protect and abort behaviour.

// File: rtl/lcd_cmd_dispatch.sv
module lcd_cmd_dispatch #(
  parameter int DEPTH     = 32,
  parameter int AW        = 8,
  parameter int SLOT_BASE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          bus_valid,
  output logic          bus_is_cmd,
  output logic [15:0]   bus_data,
  input  logic          bus_ready,
  output logic          irq
);
  localparam int CNT_W = $clog2(DEPTH);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_RUN  = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(8);
  localparam logic [AW-1:0] A_IEN  = AW'(12);
  localparam logic [AW-1:0] A_IST  = AW'(16);
  localparam logic [AW:0]   SLOT_LO = (AW+1)'(SLOT_BASE);
  localparam logic [AW:0]   SLOT_HI = (AW+1)'(SLOT_BASE + 4*DEPTH);

  logic [16:0]      slot_mem [DEPTH];
  logic [31:0]      ctrl_q;
  logic             run_q, busy_q, ien_q, ist_q;
  logic [CNT_W-1:0] idx_q, cnt_q;

  logic [AW-1:0]    slot_off;
  logic [CNT_W-1:0] sidx, eff_cnt;
  logic             slot_hit, wr_run, trig, stop, list_ok, accept, done;

  assign slot_off = host_addr - SLOT_LO[AW-1:0];
  assign sidx     = slot_off[2 +: CNT_W];
  assign slot_hit = ({1'b0, host_addr} >= SLOT_LO) && ({1'b0, host_addr} < SLOT_HI)
                    && (host_addr[1:0] == 2'b00);

  assign wr_run  = host_we && host_addr == A_RUN;
  assign trig    = wr_run && host_wdata[0] && !run_q;
  assign stop    = wr_run && !host_wdata[0];
  assign list_ok = ctrl_q[15] && ctrl_q[31:28] == 4'b0000;
  assign eff_cnt = list_ok ? ctrl_q[8 +: CNT_W] : '0;

  assign bus_valid  = busy_q && idx_q != cnt_q;
  assign bus_is_cmd = slot_mem[idx_q][16];
  assign bus_data   = slot_mem[idx_q][15:0];
  assign accept     = bus_valid && bus_ready;
  assign done       = (accept && idx_q == cnt_q - CNT_W'(1)) || (busy_q && cnt_q == '0);
  assign irq        = ist_q && ien_q;

  always_ff @(posedge clk) begin
    if (host_we && slot_hit && !busy_q)
      slot_mem[sidx] <= {host_wdata[23], host_wdata[15:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (host_we && host_addr == A_CTRL && !busy_q) ctrl_q <= host_wdata;
      if (host_we && host_addr == A_IEN) ien_q <= host_wdata[0];
      if (wr_run) run_q <= host_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (stop) begin
      busy_q <= 1'b0;
    end else if (trig) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= eff_cnt;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (accept) begin
      idx_q  <= idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ist_q <= 1'b0;
    else if (done && !stop) ist_q <= 1'b1;
    else if (host_we && host_addr == A_IST && host_wdata[0]) ist_q <= 1'b0;
  end

  always_comb begin
    host_rdata = '0;
    if (slot_hit) begin
      host_rdata[23]   = slot_mem[sidx][16];
      host_rdata[15:0] = slot_mem[sidx][15:0];
    end else begin
      case (host_addr)
        A_CTRL:  host_rdata = ctrl_q;
        A_RUN:   host_rdata[0] = run_q;
        A_STAT:  host_rdata[0] = busy_q;
        A_IEN:   host_rdata[0] = ien_q;
        A_IST:   host_rdata[0] = ist_q;
        default: host_rdata = '0;
      endcase
    end
  end

  assert_hold_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !stop |=> bus_valid && $stable(bus_is_cmd) && $stable(bus_data));

  assert_done_only_from_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist_q) |-> $past(busy_q));

  assert_busy_ends_cleanly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ist_q || $past(stop));

  assert_empty_run_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !bus_valid && !stop && !trig |=> !busy_q);

  assert_ctrl_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && host_we && host_addr == A_CTRL |=> $stable(ctrl_q));
endmodule

// File: tb/lcd_cmd_dispatch_bench.sv
`timescale 1ns/1ps
module lcd_cmd_dispatch_bench;
  localparam logic [7:0] A_CTRL = 8'h00, A_RUN = 8'h04, A_STAT = 8'h08,
                         A_IEN = 8'h0C, A_IST = 8'h10, A_SLOT = 8'h80;

  logic clk = 0, rst_n = 0, host_we = 0, bus_ready = 0;
  logic [7:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic bus_valid, bus_is_cmd, irq;
  logic [15:0] bus_data;
  int tests = 0, fails = 0;
  logic [16:0] exp_e [32];
  logic [16:0] got_e [32];

  always #2 clk = ~clk;

  lcd_cmd_dispatch u_lcd_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_valid(bus_valid),
    .bus_is_cmd(bus_is_cmd), .bus_data(bus_data), .bus_ready(bus_ready), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_word(input logic [16:0] e);
    return {8'h00, e[16], 7'h00, e[15:0]};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; #1;
    d = host_rdata;
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) begin
      exp_e[k] = {$urandom_range(1), 16'($urandom)};
      wr(A_SLOT + 8'(4*k), slot_word(exp_e[k]) | 32'hFF7F_0000);
    end
  endtask

  task automatic start();
    wr(A_RUN, 0);
    wr(A_RUN, 1);
  endtask

  task automatic run_list(input int n, input int pct);
    int got = 0, cyc = 0;
    bit pw = 0, r;
    logic [16:0] pd = 0;
    host_addr = A_STAT;
    forever begin
      @(negedge clk); #1;
      if (!host_rdata[0]) break;
      cyc++;
      if (cyc > 20000) break;
      if (pw) check(bus_valid && {bus_is_cmd, bus_data} == pd, "R5 entry held while stalled",
                    {15'b0, bus_valid, bus_is_cmd, bus_data}, {15'b0, 1'b1, pd});
      r = ($urandom_range(99) < pct);
      bus_ready = r;
      if (bus_valid && r) begin
        if (got < 32) got_e[got] = {bus_is_cmd, bus_data};
        got++;
      end
      pw = bus_valid && !r;
      pd = {bus_is_cmd, bus_data};
    end
    bus_ready = 0;
    check(got == n, "R6 busy until all entries accepted", got, n);
    for (int k = 0; k < n && k < got; k++)
      check(got_e[k] == exp_e[k], "R4 slot order and flag", got_e[k], exp_e[k]);
  endtask

  logic [31:0] d;

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(A_STAT, d); check(d == 0, "R1 busy at reset", d, 0);
    rd(A_IST, d);  check(d == 0, "R1 completion at reset", d, 0);
    rd(A_CTRL, d); check(d == 0, "R1 control at reset", d, 0);
    check(!bus_valid && !irq, "R1 valid and irq at reset", {bus_valid, irq}, 0);

    wr(A_SLOT + 8'd124, 32'hFFFF_FFFF);
    rd(A_SLOT + 8'd124, d); check(d == 32'h0080_FFFF, "R2 slot 31 masked readback", d, 32'h0080_FFFF);
    wr(A_SLOT + 8'd8, 32'h0012_3456);
    rd(A_SLOT + 8'd8, d); check(d == 32'h0000_3456, "R2 slot 2 data entry", d, 32'h0000_3456);

    for (int t = 0; t < 8; t++) begin
      int n = (t == 0) ? 31 : (t == 1 ? 1 : int'($urandom_range(31, 1)));
      int pct = (t == 2) ? 100 : int'($urandom_range(90, 10));
      bit en = 1'($urandom_range(1));
      fill(n);
      wr(A_IEN, {31'b0, en});
      wr(A_CTRL, 32'h0000_8000 | (32'(n) << 8));
      start();
      run_list(n, pct);
      rd(A_IST, d); check(d[0] == 1, "R8 completion set", d, 1);
      check(irq == en, "R8 irq follows enable", irq, en);
      wr(A_IST, 1);
      rd(A_IST, d); check(d[0] == 0 && !irq, "R8 completion cleared", {d[0], irq}, 0);
    end

    wr(A_RUN, 1);
    rd(A_STAT, d); check(d[0] == 0 && !bus_valid, "R3 rewrite of 1 starts nothing", d, 0);
    rd(A_IST, d); check(d[0] == 0, "R3 no completion from rewrite", d, 0);

    wr(A_IEN, 1);
    wr(A_CTRL, 32'h0000_8000);
    start();
    rd(A_STAT, d); check(d[0] == 1 && !bus_valid, "R7 zero count busy one cycle", {d[0], bus_valid}, 2'b10);
    rd(A_STAT, d); check(d[0] == 0, "R7 zero count busy clears", d, 0);
    rd(A_IST, d); check(d[0] == 1 && irq, "R7 zero count completes", {d[0], irq}, 2'b11);
    wr(A_IST, 1);

    wr(A_CTRL, 32'h0000_0500);
    start();
    run_list(0, 100);
    rd(A_IST, d); check(d[0] == 1, "R7 list disabled completes", d, 1);
    wr(A_IST, 1);
    wr(A_CTRL, 32'h2000_8500);
    start();
    run_list(0, 100);
    rd(A_IST, d); check(d[0] == 1, "R7 layer bit set completes", d, 1);
    wr(A_IST, 1);

    fill(10);
    wr(A_CTRL, 32'h0000_8A00);
    start();
    bus_ready = 0;
    repeat (3) @(negedge clk);
    #1 check(bus_valid && {bus_is_cmd, bus_data} == exp_e[0], "R5 stalled first entry",
             {bus_valid, bus_is_cmd, bus_data}, {1'b1, exp_e[0]});
    wr(A_SLOT, 32'h0080_BEEF);
    wr(A_CTRL, 32'h0000_8300);
    check(bus_valid && {bus_is_cmd, bus_data} == exp_e[0], "R10 offered entry unchanged",
          {bus_is_cmd, bus_data}, exp_e[0]);
    wr(A_RUN, 0);
    check(!bus_valid, "R9 valid drops on stop", bus_valid, 0);
    rd(A_STAT, d); check(d[0] == 0, "R9 busy drops on stop", d, 0);
    rd(A_IST, d); check(d[0] == 0 && !irq, "R9 no completion on abort", {d[0], irq}, 0);
    rd(A_SLOT, d); check(d == slot_word(exp_e[0]), "R10 slot write ignored while busy", d, slot_word(exp_e[0]));
    rd(A_CTRL, d); check(d == 32'h0000_8A00, "R10 control write ignored while busy", d, 32'h0000_8A00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule